// File: doc/BRIEF.md
# Character LCD 4-bit Power-up Sequencer

This block runs on the host side of a dot-matrix character LCD module. The module has already cleared itself with its own power-on reset. The block moves the module's interface into 4-bit mode, issues a fixed set of configuration commands, and then writes the single character 'H'. It drives the register-select line, the read/write line (always low), the four upper data lines and the enable strobe. It never reads the module's busy flag. Fixed wait times separate the transfers instead.

A pulse on `start_i` launches the run. `busy_o` stays high until the run ends. `done_o` then pulses for one cycle. There is no streaming data path: `start_i`, `busy_o` and `done_o` are plain control and status pins with no handshake and no back-pressure. A start pulse that arrives during a run is dropped.

The first transfer is a lone nibble. The module receives it while its bus is still 8 bits wide. Every later byte goes out as two nibbles, high nibble first. The second command sets the extended-register select bit, and the third command clears it again.

Top module: `lcd4_init_seq`

## Requirements
- R1: While reset is held and right after it is released, `lcd_en_o`, `lcd_rs_o`, `lcd_rw_o`, `lcd_data_o`, `busy_o` and `done_o` are all 0.
- R2: The first enable strobe of a run carries the single nibble 4'b0010 with RS=0. No partner nibble follows it.
- R3: After the lone nibble, each byte goes out as two strobes on `lcd_data_o[3:0]`. These lines are data bits 7..4 of the module. The high nibble goes first and the low nibble second.
- R4: The commands after the lone nibble come in this order, all with RS=0: 8'h24 (4-bit, one line, extended select set), 8'h20 (extended select cleared), 8'h02 (return home), 8'h0E (display and cursor on), 8'h06 (increment, no shift).
- R5: The last transfer is data byte 8'h48 ('H') with RS=1. No address command comes before it.
- R6: `lcd_rw_o` is 0 at every enable strobe.
- R7: Enable stays high for exactly EN_HIGH_CYC cycles (default 2). Data and RS are stable for at least one cycle before enable rises, for the whole time enable is high, and for one cycle after enable falls.
- R8: After each complete transfer (the lone nibble included), at least SHORT_WAIT cycles (default 50) pass from the enable fall to the next enable rise. After return home the wait is at least LONG_WAIT cycles (default 2000). After every other transfer the gap is below LONG_WAIT. Within one byte, the gap between the two nibbles is below SHORT_WAIT.
- R9: A `start_i` pulse while `busy_o` is high has no effect. The run still makes exactly 13 strobes and one `done_o` pulse.
- R10: `busy_o` rises in the cycle after an accepted start. `done_o` is high for exactly one cycle, no earlier than SHORT_WAIT cycles after the last enable fall, and `busy_o` is low in that same cycle.
- R11: A start after `done_o` repeats the identical sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch pulse, honoured only when idle |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse when the run completes |
| lcd_rs_o | output | 1 | Register select: 0 command, 1 data |
| lcd_rw_o | output | 1 | Read/write select, held at write (0) |
| lcd_en_o | output | 1 | Enable strobe; the module latches on its falling edge |
| lcd_data_o | output | 4 | Upper data lines, bit 3 = data bit 7 |

## Verification
A wrong step index, or a missed nibble toggle, shows on the data lines at the very next enable fall. It can appear as a wrong nibble value, a lone nibble in the wrong place, or a pair out of order. The whole stream is therefore rebuilt into bytes and compared against the ordered list. A wrong wait selection can only be seen in the spacing between strobes, tens to thousands of cycles later. For that reason every gap is measured against both bounds, so a swapped long and short delay is caught. A strobe phase error breaks the setup, hold or width rules within a few cycles of the offending edge.

// File: rtl/lcd4_init_pkg.sv
package lcd4_init_pkg;
  localparam int NUM_STEPS = 7;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int LAST_STEP = NUM_STEPS - 1;

  typedef struct packed {
    logic [7:0] code;   // byte to send
    logic       rs;     // 1 = data write
    logic       lone;   // only the high nibble goes out
    logic       slow;   // long wait follows
  } step_t;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_NIB, SEQ_WAIT} seq_state_e;
  typedef enum logic [1:0] {STB_IDLE, STB_SETUP, STB_HIGH, STB_HOLD} stb_phase_e;

  function automatic step_t step_lookup(input logic [STEP_W-1:0] idx);
    step_t s;
    s = '{code: 8'h00, rs: 1'b0, lone: 1'b0, slow: 1'b0};
    case (idx)
      3'd0: s = '{code: 8'h20, rs: 1'b0, lone: 1'b1, slow: 1'b0};
      3'd1: s.code = 8'h24;
      3'd2: s.code = 8'h20;
      3'd3: s = '{code: 8'h02, rs: 1'b0, lone: 1'b0, slow: 1'b1};
      3'd4: s.code = 8'h0E;
      3'd5: s.code = 8'h06;
      3'd6: s = '{code: 8'h48, rs: 1'b1, lone: 1'b0, slow: 1'b0};
      default: s.code = 8'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/lcd4_step_rom.sv
module lcd4_step_rom
  import lcd4_init_pkg::*;
(
  input  logic [STEP_W-1:0] idx_i,
  output step_t             step_o
);
  always_comb step_o = step_lookup(idx_i);
endmodule

// File: rtl/lcd4_strobe.sv
module lcd4_strobe
  import lcd4_init_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int HIGH_CYC  = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic en_o,
  output logic fin_o
);
  localparam int MAXC  = (SETUP_CYC > HIGH_CYC) ?
                         ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                         ((HIGH_CYC > HOLD_CYC) ? HIGH_CYC : HOLD_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  stb_phase_e        phase_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= STB_IDLE;
      cnt_q   <= '0;
      fin_o   <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      case (phase_q)
        STB_IDLE: if (go_i) begin
          phase_q <= STB_SETUP;
          cnt_q   <= CNT_W'(SETUP_CYC - 1);
        end
        STB_SETUP: if (cnt_q == '0) begin
          phase_q <= STB_HIGH;
          cnt_q   <= CNT_W'(HIGH_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        STB_HIGH: if (cnt_q == '0) begin
          phase_q <= STB_HOLD;
          cnt_q   <= CNT_W'(HOLD_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        STB_HOLD: if (cnt_q == '0) begin
          phase_q <= STB_IDLE;
          fin_o   <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= STB_IDLE;
      endcase
    end
  end

  assign en_o = (phase_q == STB_HIGH);

  // width checker for the high phase
  logic [CNT_W:0] hi_len_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    hi_len_q <= '0;
    else if (en_o) hi_len_q <= hi_len_q + 1'b1;
    else           hi_len_q <= '0;
  end

  a_r7_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_o) |-> (hi_len_q == (CNT_W+1)'(HIGH_CYC)));

  a_r7_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && phase_q != STB_IDLE) |-> 1'b0);
endmodule

// File: rtl/lcd4_wait_timer.sv
module lcd4_wait_timer #(
  parameter int LONG_WAIT  = 2000,
  parameter int SHORT_WAIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic slow_i,
  output logic exp_o
);
  localparam int MAXW = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT;
  localparam int W    = $clog2(MAXW + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= slow_i ? W'(LONG_WAIT) : W'(SHORT_WAIT);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign exp_o = (cnt_q == W'(1));

  a_r8_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (cnt_q == '0));
endmodule

// File: rtl/lcd4_init_seq.sv
module lcd4_init_seq
  import lcd4_init_pkg::*;
#(
  parameter int EN_HIGH_CYC = 2,
  parameter int SETUP_CYC   = 1,
  parameter int HOLD_CYC    = 1,
  parameter int LONG_WAIT   = 2000,
  parameter int SHORT_WAIT  = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       lcd_rs_o,
  output logic       lcd_rw_o,
  output logic       lcd_en_o,
  output logic [3:0] lcd_data_o
);
  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q, step_nx;
  logic              lo_half_q;
  logic              go, stb_fin, tmr_load, tmr_exp;
  step_t             cur, nxt;

  assign step_nx = step_q + 1'b1;

  lcd4_step_rom u_rom_cur (.idx_i(step_q),  .step_o(cur));
  lcd4_step_rom u_rom_nxt (.idx_i(step_nx), .step_o(nxt));

  lcd4_strobe #(.SETUP_CYC(SETUP_CYC), .HIGH_CYC(EN_HIGH_CYC), .HOLD_CYC(HOLD_CYC))
    u_stb (.clk(clk), .rst_n(rst_n), .go_i(go), .en_o(lcd_en_o), .fin_o(stb_fin));

  lcd4_wait_timer #(.LONG_WAIT(LONG_WAIT), .SHORT_WAIT(SHORT_WAIT))
    u_tmr (.clk(clk), .rst_n(rst_n), .load_i(tmr_load), .slow_i(cur.slow), .exp_o(tmr_exp));

  always_comb begin
    go       = 1'b0;
    tmr_load = 1'b0;
    case (state_q)
      SEQ_IDLE: go = start_i;
      SEQ_NIB:  if (stb_fin) begin
        if (cur.lone || lo_half_q) tmr_load = 1'b1;
        else                       go       = 1'b1;
      end
      SEQ_WAIT: go = tmr_exp && (step_q != STEP_W'(LAST_STEP));
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      step_q     <= '0;
      lo_half_q  <= 1'b0;
      done_o     <= 1'b0;
      lcd_rs_o   <= 1'b0;
      lcd_data_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q    <= SEQ_NIB;
          step_q     <= '0;
          lo_half_q  <= 1'b0;
          lcd_rs_o   <= 1'b0;
          lcd_data_o <= step_lookup('0).code[7:4];
        end
        SEQ_NIB: if (stb_fin) begin
          if (cur.lone || lo_half_q) begin
            state_q <= SEQ_WAIT;
          end else begin
            lo_half_q  <= 1'b1;
            lcd_data_o <= cur.code[3:0];
          end
        end
        SEQ_WAIT: if (tmr_exp) begin
          if (step_q == STEP_W'(LAST_STEP)) begin
            state_q    <= SEQ_IDLE;
            done_o     <= 1'b1;
            lcd_rs_o   <= 1'b0;
            lcd_data_o <= '0;
          end else begin
            state_q    <= SEQ_NIB;
            step_q     <= step_nx;
            lo_half_q  <= 1'b0;
            lcd_rs_o   <= nxt.rs;
            lcd_data_o <= nxt.code[7:4];
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != SEQ_IDLE);
  assign lcd_rw_o = 1'b0;

  a_r7_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en_o) |-> ($stable(lcd_data_o) && $stable(lcd_rs_o)));
  a_r7_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en_o && $past(lcd_en_o)) |-> ($stable(lcd_data_o) && $stable(lcd_rs_o)));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_en_o) |-> ($stable(lcd_data_o) && $stable(lcd_rs_o)));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r9_en_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en_o |-> busy_o);
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !tmr_exp) |=> busy_o);
endmodule

// File: tb/lcd4_init_seq_tb.sv
module lcd4_init_seq_tb;
  localparam int EN_HIGH = 2;
  localparam int LONGW   = 2000;
  localparam int SHORTW  = 50;
  localparam int NNIB    = 13;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, rs, rw, en;
  logic [3:0] data;

  lcd4_init_seq #(.EN_HIGH_CYC(EN_HIGH), .LONG_WAIT(LONGW), .SHORT_WAIT(SHORTW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .lcd_rs_o(rs), .lcd_rw_o(rw), .lcd_en_o(en), .lcd_data_o(data));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // capture
  logic [3:0] nib [0:31];
  logic       nrs [0:31];
  int rise_c [0:31];
  int fall_c [0:31];
  int n_nib, n_rise, done_cnt, done_cyc, setup_bad, hold_bad, width_bad, rw_bad;
  logic prev_en = 1'b0, hold_pend = 1'b0, prev_rs = 1'b0, rise_rs = 1'b0;
  logic [3:0] prev_data = '0, rise_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        if (data !== rise_data || rs !== rise_rs) hold_bad++;
        hold_pend = 1'b0;
      end
      if (en && !prev_en) begin
        if (data !== prev_data || rs !== prev_rs) setup_bad++;
        rise_data = data; rise_rs = rs;
        if (n_rise < 32) rise_c[n_rise] = cyc;
        n_rise++;
      end
      if (en && prev_en && (data !== rise_data || rs !== rise_rs)) hold_bad++;
      if (!en && prev_en) begin
        if (data !== rise_data || rs !== rise_rs) hold_bad++;
        if (rw !== 1'b0) rw_bad++;
        if (n_nib < 32) begin
          nib[n_nib] = data; nrs[n_nib] = rs; fall_c[n_nib] = cyc;
          if (cyc - rise_c[n_nib] != EN_HIGH) width_bad++;
        end
        n_nib++;
        hold_pend = 1'b1;
      end
      if (done) begin done_cnt++; done_cyc = cyc; end
    end
    prev_en = en; prev_data = data; prev_rs = rs;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_capture();
    n_nib = 0; n_rise = 0; done_cnt = 0; done_cyc = 0;
    setup_bad = 0; hold_bad = 0; width_bad = 0; rw_bad = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic check_stream(input string tag);
    logic [7:0] exp_b [0:5];
    exp_b[0] = 8'h24; exp_b[1] = 8'h20; exp_b[2] = 8'h02;
    exp_b[3] = 8'h0E; exp_b[4] = 8'h06; exp_b[5] = 8'h48;
    chk(n_nib == NNIB, "R9", {tag, " strobe count"}, n_nib, NNIB);
    if (n_nib != NNIB) return;
    chk(nib[0] == 4'b0010 && nrs[0] == 1'b0, "R2", {tag, " lone nibble"}, nib[0], 2);
    chk(fall_c[0] + SHORTW <= rise_c[1], "R2", {tag, " no partner after lone nibble"},
        rise_c[1] - fall_c[0], SHORTW);
    for (int b = 0; b < 6; b++) begin
      logic [7:0] got;
      got = {nib[1+2*b], nib[2+2*b]};
      if (b < 5)
        chk(got == exp_b[b] && nrs[1+2*b] == 0 && nrs[2+2*b] == 0, "R4",
            {tag, " command byte"}, got, exp_b[b]);
      else
        chk(got == exp_b[b] && nrs[11] == 1 && nrs[12] == 1, "R5",
            {tag, " data byte H"}, got, exp_b[b]);
      chk(rise_c[2+2*b] - fall_c[1+2*b] < SHORTW, "R3", {tag, " nibble pair gap"},
          rise_c[2+2*b] - fall_c[1+2*b], SHORTW);
    end
    for (int e = 0; e < 6; e++) begin
      int end_n, gap;
      end_n = (e == 0) ? 0 : 2*e;
      gap = rise_c[end_n+1] - fall_c[end_n];
      if (end_n == 6)
        chk(gap >= LONGW, "R8", {tag, " long wait after return home"}, gap, LONGW);
      else
        chk(gap >= SHORTW && gap < LONGW, "R8", {tag, " short wait"}, gap, SHORTW);
    end
    chk(rw_bad == 0, "R6", {tag, " rw low"}, rw_bad, 0);
    chk(setup_bad == 0 && hold_bad == 0, "R7", {tag, " setup/hold"}, setup_bad + hold_bad, 0);
    chk(width_bad == 0, "R7", {tag, " enable width"}, width_bad, 0);
    chk(done_cyc - fall_c[12] >= SHORTW, "R10", {tag, " done after final wait"},
        done_cyc - fall_c[12], SHORTW);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({en, rs, rw, data, busy, done} == 9'd0, "R1", "outputs in reset",
        {en, rs, rw, data, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({en, rs, rw, data, busy, done} == 9'd0, "R1", "outputs after reset",
        {en, rs, rw, data, busy, done}, 0);
  endtask

  task automatic t_basic(input string tag);
    bit ok;
    clear_capture();
    pulse_start();
    chk(busy == 1'b1, "R10", {tag, " busy after start"}, busy, 1);
    wait_done(ok);
    chk(ok, "R10", {tag, " done seen"}, ok, 1);
    chk(busy == 1'b0, "R10", {tag, " busy low with done"}, busy, 1'b0);
    @(negedge clk);
    chk(done == 1'b0, "R10", {tag, " done one cycle"}, done, 0);
    repeat (5) @(negedge clk);
    chk(done_cnt == 1, "R10", {tag, " single done"}, done_cnt, 1);
    check_stream(tag);
  endtask

  task automatic t_start_ignored();
    bit ok;
    clear_capture();
    pulse_start();
    repeat (300) @(negedge clk);
    pulse_start();
    repeat (2000) @(negedge clk);
    pulse_start();
    wait_done(ok);
    chk(ok, "R9", "done seen with extra starts", ok, 1);
    repeat (20) @(negedge clk);
    chk(done_cnt == 1, "R9", "one done despite extra starts", done_cnt, 1);
    chk(busy == 1'b0, "R9", "idle afterwards", busy, 0);
    check_stream("R9 run");
  endtask

  initial begin
    clear_capture();
    t_reset();
    t_basic("R4 first run");
    t_basic("R11 repeat run");
    t_start_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 60000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule